// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage of a 32-bit integer datapath. Each cycle it takes a first operand A, a second operand B that an upstream shifter has already prepared, a 4-bit operation code, a request to update the condition flags, the current flag values and the carry bit that the shifter pushed out. It returns the operation's value, a write-enable for the destination register and the next values of the negative, zero, carry and overflow flags. The block is purely combinational, so the enclosing pipeline chooses where to place registers around it.

Sixteen operations are available. They are addition and subtraction in both operand orders, each with an optional incoming carry, the four bitwise functions, two moves of B, and four flag-only operations. The flag-only operations are two comparisons and two bit tests. They always rewrite the flags and never write a register. For every other operation the flags change only on request. Arithmetic operations take all four flags from the adder. Bitwise and move operations take the carry from the shifter and keep the overflow flag.

Top module: `dp_alu`

## Requirements
- R1: Opcode 4 (add) returns A + B and opcode 5 (add with carry) returns A + B + Cin, modulo 2^32. Cin is flags_in[1].
- R2: Opcode 2 (subtract) returns A − B and opcode 3 (reverse subtract) returns B − A, modulo 2^32.
- R3: Opcode 6 returns A − B + Cin − 1 and opcode 7 returns B − A + Cin − 1, modulo 2^32.
- R4: The bitwise and move opcodes return the following values. Opcode 0 gives A AND B, 1 gives A XOR B, 12 gives A OR B, 14 gives A AND NOT B, 13 gives B, and 15 gives NOT B.
- R5: Opcodes 8 to 11 hold result_we low and always update the flags. Opcode 8 uses A AND B, 9 uses A XOR B, 10 uses A − B and 11 uses A + B. All other opcodes drive result_we high.
- R6: For opcodes outside 8 to 11 with set_flags low, flags_out equals flags_in.
- R7: When an arithmetic operation updates the flags, N is bit 31 of the value and Z is set when the value is zero. C is the carry out of the addition, which for a subtraction means no borrow (the exact value is at least zero). V is set when the signed result cannot be represented in 32 bits.
- R8: When a bitwise or move operation updates the flags, N and Z come from the value, C equals shift_carry and V keeps its input value.
- R9: The flag vectors place N at bit 3, Z at bit 2, C at bit 1 and V at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Request a flag update for ordinary operations |
| a | input | 32 | First operand |
| b | input | 32 | Second operand, already shifted |
| shift_carry | input | 1 | Carry pushed out by the operand shifter |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Value of the operation |
| result_we | output | 1 | Destination register write-enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
The block holds no state, so a wrong decode or adder control shows on the same evaluation as the stimulus. Examples are a swapped operand inversion, a wrong carry-in source or a flag-only opcode treated as a write. Each one appears at once as a wrong result, a wrong write-enable or a wrong flag bit. The sweep crosses every opcode with boundary operands such as zero, all ones and the signed extremes, with every flag-request setting and with several incoming flag patterns. This brings carry and overflow errors out in the cycle the vector is applied.

// File: rtl/dp_alu_pkg.sv
// Shared definitions for the data-processing ALU: operation codes,
// per-operation control word and the condition flag layout.
package dp_alu_pkg;

    localparam int FLAG_W = 4;

    // Operation codes; the numeric values are part of the block interface.
    typedef enum logic [3:0] {
        OP_AND    = 4'h0,
        OP_XOR    = 4'h1,
        OP_SUB    = 4'h2,
        OP_RSUB   = 4'h3,
        OP_ADD    = 4'h4,
        OP_ADDC   = 4'h5,
        OP_SUBC   = 4'h6,
        OP_RSUBC  = 4'h7,
        OP_TSTAND = 4'h8,
        OP_TSTXOR = 4'h9,
        OP_CMPSUB = 4'hA,
        OP_CMPADD = 4'hB,
        OP_OR     = 4'hC,
        OP_MOVB   = 4'hD,
        OP_CLR    = 4'hE,
        OP_MOVNB  = 4'hF
    } dp_op_e;

    // Source of the adder carry-in.
    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2
    } cin_sel_e;

    // Function of the bitwise unit.
    typedef enum logic [2:0] {
        LF_AND   = 3'd0,
        LF_OR    = 3'd1,
        LF_XOR   = 3'd2,
        LF_CLR   = 3'd3,
        LF_PASS  = 3'd4,
        LF_NPASS = 3'd5
    } logic_fn_e;

    // Decoded control for one operation.
    typedef struct packed {
        logic      inv_a;
        logic      inv_b;
        cin_sel_e  cin_sel;
        logic      is_arith;
        logic      flag_only;
        logic_fn_e lfn;
    } dp_ctrl_t;

    // Flags; N lands in the most significant bit of the packed vector.
    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } dp_flags_t;

endpackage

// File: rtl/dp_op_decode.sv
// Operation decoder.
// Turns the 4-bit operation code into adder and bitwise-unit controls.
// Assumes the code space is fully populated; every value has a meaning.
module dp_op_decode
    import dp_alu_pkg::*;
(
    input  logic [3:0] opcode,
    output dp_ctrl_t   ctrl
);

    dp_op_e op;
    assign op = dp_op_e'(opcode);

    // Map each operation onto operand inversion, carry source and class.
    always_comb begin
        ctrl = '{inv_a: 1'b0, inv_b: 1'b0, cin_sel: CIN_ZERO,
                 is_arith: 1'b0, flag_only: 1'b0, lfn: LF_AND};
        unique case (op)
            OP_AND:    ctrl.lfn = LF_AND;
            OP_XOR:    ctrl.lfn = LF_XOR;
            OP_OR:     ctrl.lfn = LF_OR;
            OP_CLR:    ctrl.lfn = LF_CLR;
            OP_MOVB:   ctrl.lfn = LF_PASS;
            OP_MOVNB:  ctrl.lfn = LF_NPASS;
            OP_TSTAND: begin ctrl.lfn = LF_AND; ctrl.flag_only = 1'b1; end
            OP_TSTXOR: begin ctrl.lfn = LF_XOR; ctrl.flag_only = 1'b1; end
            OP_ADD:    ctrl.is_arith = 1'b1;
            OP_ADDC:   begin ctrl.is_arith = 1'b1; ctrl.cin_sel = CIN_FLAG; end
            OP_SUB:    begin ctrl.is_arith = 1'b1; ctrl.inv_b = 1'b1; ctrl.cin_sel = CIN_ONE; end
            OP_RSUB:   begin ctrl.is_arith = 1'b1; ctrl.inv_a = 1'b1; ctrl.cin_sel = CIN_ONE; end
            OP_SUBC:   begin ctrl.is_arith = 1'b1; ctrl.inv_b = 1'b1; ctrl.cin_sel = CIN_FLAG; end
            OP_RSUBC:  begin ctrl.is_arith = 1'b1; ctrl.inv_a = 1'b1; ctrl.cin_sel = CIN_FLAG; end
            OP_CMPSUB: begin ctrl.is_arith = 1'b1; ctrl.inv_b = 1'b1; ctrl.cin_sel = CIN_ONE;
                             ctrl.flag_only = 1'b1; end
            OP_CMPADD: begin ctrl.is_arith = 1'b1; ctrl.flag_only = 1'b1; end
            default:   ctrl.lfn = LF_AND;
        endcase
    end

    // Guard: never invert both adder inputs at once (R2, R3).
    always_comb begin
        a_r2_single_invert: assert (!(ctrl.inv_a && ctrl.inv_b))
            else $error("decoder inverts both operands");
    end

endmodule

// File: rtl/dp_adder.sv
// Adder with optional input inversion.
// Computes x + y + cin, where x and y are the operands, each optionally
// complemented. It reports the carry out and the signed overflow.
// Assumes at most one operand is inverted per operation.
module dp_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             inv_a,
    input  logic             inv_b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] x;
    logic [WIDTH-1:0] y;

    // Conditionally complement the operands ahead of the carry chain.
    always_comb begin
        x = inv_a ? ~opa : opa;
        y = inv_b ? ~opb : opb;
    end

    // Full-width addition with carry out.
    always_comb begin
        {cout, sum} = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
    end

    // Overflow: like-signed adder inputs producing an opposite-signed sum.
    always_comb begin
        ovf = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
    end

    // Guard: subtracting equal operands gives zero without a borrow (R2, R7).
    always_comb begin
        if (inv_b && !inv_a && cin && (opa == opb)) begin
            a_r2_equal_sub: assert ((sum == '0) && cout && !ovf)
                else $error("a-a not zero with carry");
        end
    end

endmodule

// File: rtl/dp_logic_unit.sv
// Bitwise unit: AND, OR, XOR, clear-bits and the two moves of B.
// Assumes B already carries any shift applied to the second operand.
module dp_logic_unit
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic_fn_e        lfn,
    output logic [WIDTH-1:0] res
);

    // Select the bitwise function.
    always_comb begin
        unique case (lfn)
            LF_AND:   res = opa & opb;
            LF_OR:    res = opa | opb;
            LF_XOR:   res = opa ^ opb;
            LF_CLR:   res = opa & ~opb;
            LF_PASS:  res = opb;
            LF_NPASS: res = ~opb;
            default:  res = opa & opb;
        endcase
    end

    // Guard: clearing leaves no bit that B had set (R4).
    always_comb begin
        if (lfn == LF_CLR) begin
            a_r4_clear_disjoint: assert ((res & opb) == '0)
                else $error("clear left bits of b");
        end
    end

endmodule

// File: rtl/dp_flag_unit.sv
// Next-flag generator.
// Arithmetic operations take all four flags from the adder. Bitwise
// operations take C from the shifter and keep V. Without an update the
// flags pass through unchanged.
// Assumes value is the operation's full result, also for flag-only operations.
module dp_flag_unit
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             update,
    input  logic             is_arith,
    input  logic [WIDTH-1:0] value,
    input  logic             add_cout,
    input  logic             add_ovf,
    input  logic             shift_carry,
    input  dp_flags_t        flags_in,
    output dp_flags_t        flags_out
);

    localparam int MSB = WIDTH - 1;

    logic      is_zero;
    dp_flags_t fresh;

    // Zero detection over the whole value.
    always_comb begin
        is_zero = (value == '0);
    end

    // Assemble updated flags according to the operation class.
    always_comb begin
        fresh.n = value[MSB];
        fresh.z = is_zero;
        fresh.c = is_arith ? add_cout : shift_carry;
        fresh.v = is_arith ? add_ovf  : flags_in.v;
    end

    // Choose between updated and held flags.
    always_comb begin
        flags_out = update ? fresh : flags_in;
    end

endmodule

// File: rtl/dp_alu.sv
// Data-processing ALU, top level.
// Combinational. It runs one of sixteen operations on A and a pre-shifted B.
// It drives the value, a destination write-enable and the next {N,Z,C,V}.
// Assumes the flag vectors hold N,Z,C,V in bits 3..0.
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]        opcode,
    input  logic              set_flags,
    input  logic [WIDTH-1:0]  a,
    input  logic [WIDTH-1:0]  b,
    input  logic              shift_carry,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [WIDTH-1:0]  result,
    output logic              result_we,
    output logic [FLAG_W-1:0] flags_out
);

    localparam int MSB = WIDTH - 1;

    dp_ctrl_t         ctrl;
    dp_flags_t        cur_flags;
    dp_flags_t        nxt_flags;
    logic             add_cin;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;
    logic             add_ovf;
    logic [WIDTH-1:0] log_res;
    logic             do_update;

    assign cur_flags = dp_flags_t'(flags_in);

    dp_op_decode u_decode (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    // Carry-in source for the adder.
    always_comb begin
        unique case (ctrl.cin_sel)
            CIN_ONE:  add_cin = 1'b1;
            CIN_FLAG: add_cin = cur_flags.c;
            default:  add_cin = 1'b0;
        endcase
    end

    dp_adder #(.WIDTH(WIDTH)) u_adder (
        .opa   (a),
        .opb   (b),
        .inv_a (ctrl.inv_a),
        .inv_b (ctrl.inv_b),
        .cin   (add_cin),
        .sum   (add_sum),
        .cout  (add_cout),
        .ovf   (add_ovf)
    );

    dp_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .opa (a),
        .opb (b),
        .lfn (ctrl.lfn),
        .res (log_res)
    );

    // Result select, write-enable and update request.
    always_comb begin
        result    = ctrl.is_arith ? add_sum : log_res;
        result_we = !ctrl.flag_only;
        do_update = ctrl.flag_only || set_flags;
    end

    dp_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .update      (do_update),
        .is_arith    (ctrl.is_arith),
        .value       (result),
        .add_cout    (add_cout),
        .add_ovf     (add_ovf),
        .shift_carry (shift_carry),
        .flags_in    (cur_flags),
        .flags_out   (nxt_flags)
    );

    assign flags_out = nxt_flags;

    // Port-level guards relating the opcode, result and flags.
    always_comb begin
        a_r5_no_write: assert (!((opcode[3:2] == 2'b10) && result_we))
            else $error("flag-only opcode wrote a result");
        if (opcode[3:2] == 2'b10) begin
            a_r7_zero_flag: assert (flags_out[2] == (result == '0))
                else $error("Z disagrees with value");
            a_r9_neg_flag: assert (flags_out[3] == result[MSB])
                else $error("N disagrees with value");
        end
        if (!set_flags && (opcode[3:2] != 2'b10)) begin
            a_r6_hold: assert (flags_out == flags_in)
                else $error("flags changed without request");
        end
    end

endmodule

// File: tb/dp_alu_bench.sv
// Self-checking bench: sweeps every opcode over boundary operands and flag
// settings and compares against an arithmetic model built from the requirements.
module dp_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  opcode = '0;
    logic        set_flags = 1'b0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic        shift_carry = 1'b0;
    logic [3:0]  flags_in = '0;
    logic [31:0] result;
    logic        result_we;
    logic [3:0]  flags_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] corners [10];

    always #10 clk = ~clk;   // 50 MHz

    dp_alu u_dp_alu (
        .opcode      (opcode),
        .set_flags   (set_flags),
        .a           (a),
        .b           (b),
        .shift_carry (shift_carry),
        .flags_in    (flags_in),
        .result      (result),
        .result_we   (result_we),
        .flags_out   (flags_out)
    );

    function automatic string val_req(input logic [3:0] op);
        case (op)
            4'h4, 4'h5: return "R1";
            4'h2, 4'h3: return "R2";
            4'h6, 4'h7: return "R3";
            default:    return "R4";
        endcase
    endfunction

    // Reference model straight from the requirement text.
    task automatic model(input logic [3:0] op, input logic [31:0] ia, input logic [31:0] ib,
                         input logic sf, input logic sc, input logic [3:0] fi,
                         output logic [31:0] er, output logic ewe, output logic [3:0] ef,
                         output string freq);
        longint ua = longint'(ia);
        longint ub = longint'(ib);
        longint sa = longint'($signed(ia));
        longint sb = longint'($signed(ib));
        longint c  = longint'(fi[1]);
        longint u = 0, s = 0;
        bit arith = 1, addlike = 1, upd;
        logic cf, vf;
        case (op)
            4'h4, 4'hB: begin u = ua + ub;         s = sa + sb;         end
            4'h5:       begin u = ua + ub + c;     s = sa + sb + c;     end
            4'h2, 4'hA: begin u = ua - ub;         s = sa - sb;         addlike = 0; end
            4'h3:       begin u = ub - ua;         s = sb - sa;         addlike = 0; end
            4'h6:       begin u = ua - ub + c - 1; s = sa - sb + c - 1; addlike = 0; end
            4'h7:       begin u = ub - ua + c - 1; s = sb - sa + c - 1; addlike = 0; end
            default: arith = 0;
        endcase
        if (arith) begin
            er = u[31:0];
            cf = addlike ? (u >= 64'sd4294967296) : (u >= 0);
            vf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        end else begin
            case (op)
                4'h0, 4'h8: er = ia & ib;
                4'h1, 4'h9: er = ia ^ ib;
                4'hC:       er = ia | ib;
                4'hE:       er = ia & ~ib;
                4'hD:       er = ib;
                default:    er = ~ib;
            endcase
            cf = sc;
            vf = fi[0];
        end
        ewe = !(op >= 4'h8 && op <= 4'hB);
        upd = !ewe || sf;
        ef  = upd ? {er[31], (er == 32'h0), cf, vf} : fi;
        freq = !upd ? "R6" : (!ewe ? "R5" : (arith ? "R7" : "R8"));
    endtask

    task automatic apply_check(input logic [3:0] op, input logic [31:0] ia, input logic [31:0] ib,
                               input logic sf, input logic sc, input logic [3:0] fi);
        logic [31:0] er; logic ewe; logic [3:0] ef; string fr;
        @(posedge clk);
        opcode = op; a = ia; b = ib; set_flags = sf; shift_carry = sc; flags_in = fi;
        model(op, ia, ib, sf, sc, fi, er, ewe, ef, fr);
        @(negedge clk);
        n_checks++;
        if (result_we !== ewe) begin
            n_fail++;
            $display("FAIL R5 op=%h we actual=%b expected=%b", op, result_we, ewe);
        end
        if (ewe) begin
            n_checks++;
            if (result !== er) begin
                n_fail++;
                $display("FAIL %s op=%h a=%h b=%h fi=%h result actual=%h expected=%h",
                         val_req(op), op, ia, ib, fi, result, er);
            end
        end
        n_checks++;
        if (flags_out !== ef) begin
            n_fail++;
            $display("FAIL %s op=%h a=%h b=%h sf=%b sc=%b fi=%h flags actual=%h expected=%h",
                     fr, op, ia, ib, sf, sc, fi, flags_out, ef);
        end
    endtask

    // Directed check of the flag bit order (R9).
    task automatic check_order(input logic [31:0] ia, input logic [31:0] ib, input logic [3:0] exp);
        @(posedge clk);
        opcode = 4'hA; a = ia; b = ib; set_flags = 1'b0; shift_carry = 1'b0; flags_in = 4'h0;
        @(negedge clk);
        n_checks++;
        if (flags_out !== exp) begin
            n_fail++;
            $display("FAIL R9 compare %h,%h flags actual=%b expected=%b", ia, ib, flags_out, exp);
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // Main stimulus.
    initial begin
        logic [3:0]  fset [4];
        logic [31:0] lfsr;
        fset = '{4'h0, 4'hF, 4'h5, 4'hA};
        corners = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h8000_0000,
                    32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h8000_0001, 32'h5555_5555,
                    32'hAAAA_AAAA, 32'h1234_5678};
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle-input state: AND of zeros writes zero, flags pass (R4, R6).
        apply_check(4'h0, 32'h0, 32'h0, 1'b0, 1'b0, 4'h0);

        // Flag order: 0-1 sets only N; 5-5 sets Z and C (R9).
        check_order(32'd0, 32'd1, 4'b1000);
        check_order(32'd5, 32'd5, 4'b0110);
        check_order(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b1001);

        // Sweep opcodes x flag request x shifter carry x flags x corner operands (R1..R8).
        for (int op = 0; op < 16; op++)
            for (int sf = 0; sf < 2; sf++)
                for (int fi = 0; fi < 4; fi++)
                    for (int sc = 0; sc < 2; sc++)
                        for (int ia = 0; ia < 10; ia++)
                            for (int ib = 0; ib < 10; ib++)
                                apply_check(4'(op), corners[ia], corners[ib],
                                            1'(sf), 1'(sc), fset[fi]);

        // Pseudo-random operands over every opcode.
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra, rb;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ra = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            rb = lfsr ^ {lfsr[15:0], lfsr[31:16]};
            apply_check(4'(i % 16), ra, rb, ra[3], rb[7], ra[11:8]);
        end

        finish_run();
    end

endmodule